// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Threshold Flag

This block is a first-in first-out buffer, 1024 words of 9 bits by default. A writer side and a reader side each run on their own clock. Each side raises a request that is honoured on its clock's rising edge if the buffer can take it. The buffer crosses its pointers between the two clock domains in gray code. It reports four status outputs: empty (active low, reader domain), full (active low, writer domain), half-full, and a single threshold flag. The threshold flag warns when the fill level is close to either end of the range.

The threshold flag uses one offset X for both ends. A falling edge on the define input, sampled on the write clock, copies the word on the write-data bus into a holding register. The offset takes effect during a reset. If define is low while reset is in force, the held value becomes X. If define is high, X returns to 256. Keeping define low across later resets keeps the held offset. After power-up the block must be reset before use.

Top module: `flag_fifo`

## Requirements
- R1: With `wrEn` high and `fullN` high, the rising edge of `wrClk` stores `wrData`. With `rdEn` high and `emptyN` high, the rising edge of `rdClk` puts the oldest stored word on `rdData`. Words leave in the order they arrived.
- R2: A write request made while `fullN` is low leaves the stored words unchanged, and the later read-out shows no extra word.
- R3: A read request made while `emptyN` is low changes neither `rdData` nor the read position.
- R4: `emptyN` is low exactly when the reader domain sees no words. A write becomes visible to the reader two `rdClk` edges after the write edge.
- R5: `fullN` is low exactly when the writer-domain count is 1024. A read becomes visible to the writer two `wrClk` edges after the read edge.
- R6: `halfFull` is high when the writer-domain count is 512 or more, and low otherwise.
- R7: `almostFlag` is high when the writer-domain count is at most X or at least 1024 − X, and low strictly between those bounds.
- R8: A high-to-low change of `defineIn`, seen on consecutive `wrClk` edges, copies `wrData[8:0]` into the held offset. A low level held without a new falling edge copies nothing more.
- R9: On each `wrClk` edge while the writer-domain reset is in force, X is loaded with the held offset if `defineIn` is low, or with 256 if it is high. X may be 0 to 511 and survives resets taken with `defineIn` low.
- R10: After a read empties the buffer, `rdData` keeps the last word read.
- R11: `rstN` low clears both pointers at once: `emptyN` = 0, `fullN` = 1, `halfFull` = 0, `almostFlag` = 1. Release takes effect after two edges of each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write (load) clock |
| rdClk | input | 1 | Read (unload) clock |
| rstN | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| wrEn | input | 1 | Write request |
| wrData | input | 9 | Write data; also the offset source for define |
| defineIn | input | 1 | Offset define strobe, falling edge captures |
| rdEn | input | 1 | Read request |
| rdData | output | 9 | Last word read |
| emptyN | output | 1 | Low when empty (read domain) |
| fullN | output | 1 | Low when full (write domain) |
| halfFull | output | 1 | High at 512 or more words |
| almostFlag | output | 1 | High near either end of the fill range |

## Verification
The assertions assume both clocks run and that `rstN` is held low for at least two edges of each clock. They also assume `defineIn` does not fall on the same edge on which the reset is released, so capturing and arming never coincide. The bench drives both domains from one clock, which makes the two-edge synchronizer delay exact. It holds `defineIn` steady for several cycles around every reset release, and it changes the define level only from idle cycles that are separate from the arming window.

// File: rtl/flagfifo_pkg.sv
package flagfifo_pkg;
  // Strobes handed from control to the storage datapath.
  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
  } memStrobes_t;
endpackage

// File: rtl/flagfifo_rst_sync.sv
module flagfifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstNIn,
  output logic rstNOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstNIn) begin
    if (!rstNIn) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstNOut = chain[STAGES-1];
endmodule

// File: rtl/flagfifo_mem.sv
module flagfifo_mem
  import flagfifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 10
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  memStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStrobe) store[wrAddr] <= wrData;
  end

  // Output register holds its word until the next accepted read.
  always_ff @(posedge rdClk) begin
    if (strobes.rdStrobe) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/flagfifo_ctrl.sv
module flagfifo_ctrl
  import flagfifo_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int OFS_W       = 9,
  parameter int DEFAULT_OFS = 256
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [OFS_W-1:0]  wrData,
  input  logic              defineIn,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output memStrobes_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfFull,
  output logic              almostFlag
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int EXT_W = PTR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, rdGraySync1, rdGraySync2, wrCount;
  logic [PTR_W-1:0] rdGray;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin       <= '0;
      wrGray      <= '0;
      rdGraySync1 <= '0;
      rdGraySync2 <= '0;
    end else begin
      if (strobes.wrStrobe) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
      rdGraySync1 <= rdGray;
      rdGraySync2 <= rdGraySync1;
    end
  end

  assign wrCount  = wrBin - fromGray(rdGraySync2);
  assign fullN    = (wrCount != PTR_W'(DEPTH));
  assign halfFull = (wrCount >= PTR_W'(HALF));
  assign wrAddr   = wrBin[ADDR_W-1:0];

  // Offset capture and arming; neither register is cleared by reset.
  logic             defineQ;
  logic [OFS_W-1:0] heldOfs, activeOfs;

  always_ff @(posedge wrClk) begin
    defineQ <= defineIn;
    if (defineQ && !defineIn) heldOfs <= wrData;
    if (!wrRstN) activeOfs <= defineIn ? OFS_W'(DEFAULT_OFS) : heldOfs;
  end

  logic [EXT_W-1:0] cntExt, ofsExt;
  assign cntExt     = EXT_W'(wrCount);
  assign ofsExt     = EXT_W'(activeOfs);
  assign almostFlag = (cntExt <= ofsExt) || ((cntExt + ofsExt) >= EXT_W'(DEPTH));

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rdBin, wrGraySync1, wrGraySync2;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin       <= '0;
      rdGray      <= '0;
      wrGraySync1 <= '0;
      wrGraySync2 <= '0;
    end else begin
      if (strobes.rdStrobe) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= toGray(rdBin + 1'b1);
      end
      wrGraySync1 <= wrGray;
      wrGraySync2 <= wrGraySync1;
    end
  end

  assign emptyN = (rdGray != wrGraySync2);
  assign rdAddr = rdBin[ADDR_W-1:0];

  assign strobes = '{wrStrobe: wrEn & fullN, rdStrobe: rdEn & emptyN};
endmodule

// File: rtl/flag_fifo.sv
module flag_fifo
  import flagfifo_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int ADDR_W      = 10,
  parameter int DEFAULT_OFS = 256
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              defineIn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfFull,
  output logic              almostFlag
);
  logic              wrRstN, rdRstN;
  memStrobes_t       strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  flagfifo_rst_sync #(.STAGES(2)) u_wrRst (.clk(wrClk), .rstNIn(rstN), .rstNOut(wrRstN));
  flagfifo_rst_sync #(.STAGES(2)) u_rdRst (.clk(rdClk), .rstNIn(rstN), .rstNOut(rdRstN));

  flagfifo_ctrl #(
    .ADDR_W(ADDR_W), .OFS_W(DATA_W), .DEFAULT_OFS(DEFAULT_OFS)
  ) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .defineIn(defineIn),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN), .halfFull(halfFull), .almostFlag(almostFlag)
  );

  flagfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wrClk(wrClk), .rdClk(rdClk), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/flagfifo_checker.sv
module flagfifo_checker #(
  parameter int DATA_W = 9
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              wrRstN,
  input logic              rdRstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              emptyN,
  input logic              fullN,
  input logic              halfFull,
  input logic              almostFlag
);
  // R5: the buffer can only become full through an accepted write request
  a_r5_full_by_write: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $fell(fullN) |-> $past(wrEn));

  // R6: a full buffer is at least half full
  a_r6_full_is_half: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !fullN |-> halfFull);

  // R7: a full buffer lies inside the upper threshold band
  a_r7_full_is_near: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !fullN |-> almostFlag);

  // R4: the buffer can only become empty through a read request
  a_r4_empty_by_read: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $fell(emptyN) |-> $past(rdEn));

  // R3: nothing is read while empty
  a_r3_no_read_when_empty: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !emptyN |=> $stable(rdData));

  // R10: the word that emptied the buffer stays on the output
  a_r10_last_word_held: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $fell(emptyN) |=> $stable(rdData));
endmodule

bind flag_fifo flagfifo_checker #(.DATA_W(DATA_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .wrRstN(wrRstN), .rdRstN(rdRstN),
  .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .emptyN(emptyN),
  .fullN(fullN), .halfFull(halfFull), .almostFlag(almostFlag)
);

// File: tb/flag_fifo_tb.sv
`timescale 1ns/1ps
module flag_fifo_tb;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, defineIn = 1'b1;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic emptyN, fullN, halfFull, almostFlag;

  always #4 clk = ~clk;

  flag_fifo u_dut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .defineIn(defineIn), .rdEn(rdEn), .rdData(rdData), .emptyN(emptyN),
    .fullN(fullN), .halfFull(halfFull), .almostFlag(almostFlag)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  string tag = "R11";

  // Behavioural reference
  int q[$];
  int wrP, rdP, wrP1, wrP2, rdP1, rdP2;
  int xOfs = 256, held = 0, lastRead = 0;
  bit prevDef = 1, haveRead = 0, rs1 = 0, rsOut = 0, cmpOn = 0;

  task automatic check(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelClear();
    q.delete();
    wrP = 0; rdP = 0; wrP1 = 0; wrP2 = 0; rdP1 = 0; rdP2 = 0;
  endtask

  task automatic tick(bit w, bit r, int d, bit def);
    int wc;
    bit mFullN, mEmptyN, wAcc, rAcc, oldOut;
    wrEn = w; rdEn = r; wrData = 9'(d); defineIn = def;
    wc = wrP - rdP2;
    mFullN = (wc != DEPTH);
    mEmptyN = (rdP != wrP2);
    wAcc = w && mFullN && rsOut;
    rAcc = r && mEmptyN && rsOut;
    @(posedge clk);
    oldOut = rsOut;
    rsOut = rs1; rs1 = rstN;
    if (!oldOut) xOfs = def ? 256 : held;
    if (prevDef && !def) held = d & 511;
    prevDef = def;
    if (!oldOut) modelClear();
    else begin
      rdP2 = rdP1; rdP1 = rdP; wrP2 = wrP1; wrP1 = wrP;
      if (wAcc) begin q.push_back(d & 511); wrP++; end
      if (rAcc) begin lastRead = q.pop_front(); rdP++; haveRead = 1; end
    end
    @(negedge clk);
    if (cmpOn) begin
      wc = wrP - rdP2;
      check("emptyN (R4)", int'(emptyN), int'(rdP != wrP2));
      check("fullN (R5)", int'(fullN), int'(wc != DEPTH));
      check("halfFull (R6)", int'(halfFull), int'(wc >= DEPTH/2));
      check("almostFlag (R7)", int'(almostFlag), int'(wc <= xOfs || wc >= DEPTH - xOfs));
      if (haveRead) check("rdData (R1/R10)", int'(rdData), lastRead);
    end
  endtask

  task automatic doReset(bit def);
    tag = "R11 reset";
    rstN = 1'b0; rs1 = 0; rsOut = 0; modelClear();
    for (int i = 0; i < 4; i++) tick(0, 0, 0, def);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) tick(0, 0, 0, def);
  endtask

  task automatic defineOfs(int v);
    tag = "R8 capture";
    tick(0, 0, v, 1);
    tick(0, 0, v, 1);
    tick(0, 0, v, 0);
    tick(0, 0, (v + 3) & 511, 0);  // low level held: no new capture
  endtask

  task automatic fillDrain(int n, string t);
    tag = t;
    for (int i = 0; i < n; i++) tick(1, 0, (i * 37 + 11) & 511, 0);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 0);
    for (int i = 0; i < n; i++) tick(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 0);
  endtask

  task automatic traffic(int n, int wPct, int rPct, bit def, string t);
    tag = t;
    for (int i = 0; i < n; i++)
      tick(($urandom % 100) < wPct, ($urandom % 100) < rPct, $urandom % 512, def);
  endtask

  initial begin
    void'($urandom(7));
    modelClear();
    rstN = 1'b0;
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 1);
    cmpOn = 1;
    // R11 reset state with default offset (R9: define high -> 256)
    doReset(1);
    tag = "R11 after reset";
    check("emptyN (R11)", int'(emptyN), 0);
    check("fullN (R11)", int'(fullN), 1);
    check("halfFull (R11)", int'(halfFull), 0);
    check("almostFlag (R11)", int'(almostFlag), 1);

    // R1 R2 R5 R6 R7: fill past full (extra writes ignored), then over-drain (R3 R10)
    tag = "R1 R2 fill";
    for (int i = 0; i < DEPTH + 6; i++) tick(1, 0, (i * 37 + 11) & 511, 1);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 1);
    tag = "R1 R3 R10 drain";
    for (int i = 0; i < DEPTH + 6; i++) tick(0, 1, 0, 1);

    // R8 R9: program X = 5 and arm it
    defineOfs(5);
    doReset(0);
    fillDrain(DEPTH, "R7 R9 X=5");
    // R9: reset again with define low keeps X = 5
    doReset(0);
    fillDrain(40, "R9 retain X=5");

    // X = 0 edge case
    defineOfs(0);
    doReset(0);
    traffic(3000, 60, 45, 0, "R7 X=0 traffic");
    traffic(2500, 40, 70, 0, "R4 R10 X=0 drain");

    // X = 511 edge case
    defineOfs(511);
    doReset(0);
    traffic(3000, 65, 40, 0, "R7 X=511 traffic");
    traffic(2500, 30, 80, 0, "R3 X=511 drain");

    // R9: define high during reset returns to 256
    tick(0, 0, 0, 1);
    tick(0, 0, 0, 1);
    doReset(1);
    traffic(3000, 55, 50, 1, "R9 default traffic");

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule